// File: doc/BRIEF.md
# Multi-Size Set-Associative Translation Cache

This block caches finished address translations for an I/O memory management unit. It holds 8 ways in each of 64 sets, and every entry carries its own page size: 4 KiB, 64 KiB or 1 MiB. A requester presents a 32-bit virtual address on the lookup port. One cycle later the block answers with a hit and the physical address, with a miss, or with a multi-hit fault when more than one valid entry covers the address. A table walker installs completed translations through the fill port. Software removes entries with a whole-cache flush or with a per-address invalidate.

The set is always picked by the four lowest virtual page-number bits above the 4 KiB offset plus the next two (address bits 17:12), whatever the page size. A 64 KiB page is therefore cached in one of 16 neighbouring sets and a 1 MiB page in any of the 64 sets. The copy lands in the set chosen by the address that was walked. To remove a large page completely, software issues one per-address invalidate for each 4 KiB step the page could occupy: 16 for a 64 KiB page and 64 for a 1 MiB page. Within a set a victim is picked either by least-recently-used order or by a per-set round-robin pointer, under a mode input.

Top module: `tlb_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. rsp_valid is high exactly in the cycle after a cycle with lkp_req high, and low otherwise.
- R2: A lookup uses set lkp_va[17:12]. On a single hit, rsp_pa takes its upper bits from the entry's physical page and its lower bits from lkp_va. The lower part is 12 bits for size code 0 (4 KiB), 16 bits for code 1 (64 KiB) and 20 bits for code 2 (1 MiB).
- R3: An entry matches only when the lookup page number equals its stored page number above the entry's size. Differences below the size are ignored. An address whose set holds no matching entry misses, even when a large page covering it sits in another set.
- R4: When two or more valid entries in the selected set match, the response shows rsp_multi=1 and rsp_hit=0.
- R5: An accepted fill is written to set fill_vpn[5:0], into the lowest-numbered invalid way if there is one. A fill with size code 3 is dropped.
- R6: With lru_mode=1 and a full set, a fill replaces the way that was least recently filled or single-hit in that set.
- R7: With lru_mode=0 and a full set, a fill replaces the way named by that set's pointer. The pointer is 0 after reset and advances by one, modulo 8, each time it picks a victim.
- R8: inv_all clears every entry at the next edge.
- R9: inv_one clears, in set inv_vpn[5:0] only, every entry that covers inv_vpn. Copies of the same large page in other sets stay valid.
- R10: A lookup in the same cycle as a fill or invalidate answers from the contents before that edge. A fill in a cycle with inv_all or inv_one high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lru_mode | input | 1 | 1 selects least-recently-used replacement, 0 selects round-robin |
| lkp_req | input | 1 | Lookup request |
| lkp_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response present (one cycle after lkp_req) |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_multi | output | 1 | More than one entry matched (fault) |
| rsp_pa | output | 32 | Translated physical address, meaningful with rsp_hit |
| fill_req | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number (4 KiB units) of the walked address |
| fill_ppn | input | 20 | Physical page base (4 KiB units), low bits below size ignored |
| fill_size | input | 2 | Page size code: 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = reserved |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate entries covering inv_vpn in its set |
| inv_vpn | input | 20 | Virtual page number for the per-address invalidate |

## Verification
Three pairs of functions can coincide in one cycle: a lookup with a fill of the same page, a lookup with a flush, and a fill with either kind of invalidate. Directed steps drive each pair on the same edge. The lookup must then report the contents from before that edge, a following lookup must show the updated contents, and the fill must leave no trace when an invalidate came with it. The random phase produces the same overlaps at a steady rate. A reference model in the bench, which applies lookup-then-update order, judges every response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Page size codes carried by each entry
  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_MID   = 2'd1,
    PG_BIG   = 2'd2,
    PG_RSVD  = 2'd3
  } pg_size_e;

  // Number of page-number bits below the page size (not compared in the tag)
  function automatic int unsigned size_low_bits(logic [1:0] sz, int unsigned mid_x,
                                                int unsigned big_x);
    case (sz)
      2'd1:    return mid_x;
      2'd2:    return big_x;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
// Compares one probe page number against all ways of a set, each masked by its size.
module tlb_match
  import tlb_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int VPN_W = 20,
  parameter int MID_X = 4,
  parameter int BIG_X = 8
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][1:0]       way_size,
  input  logic [WAYS-1:0][VPN_W-1:0] way_vpn,
  input  logic [VPN_W-1:0]           probe_vpn,
  output logic [WAYS-1:0]            way_hit
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] cmp_mask;
    assign cmp_mask   = {VPN_W{1'b1}} << size_low_bits(way_size[w], MID_X, BIG_X);
    assign way_hit[w] = way_valid[w] && (((way_vpn[w] ^ probe_vpn) & cmp_mask) == '0);
  end

endmodule

// File: rtl/tlb_victim.sv
// Picks the way a fill writes: first free way, else LRU or round-robin choice.
module tlb_victim #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][WAY_W-1:0] way_age,
  input  logic [WAY_W-1:0]           rr_ptr,
  input  logic                       lru_mode,
  output logic [WAY_W-1:0]           victim,
  output logic                       set_full
);

  always_comb begin
    set_full = &way_valid;
    victim   = rr_ptr;
    if (!set_full) begin
      victim = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!way_valid[w]) victim = WAY_W'(w);
      end
    end else if (lru_mode) begin
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (way_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/tlb_repl.sv
// Per-set replacement state: age rank per way and a round-robin pointer.
module tlb_repl #(
  parameter int WAYS  = 8,
  parameter int SETS  = 64,
  parameter int WAY_W = 3,
  parameter int SET_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch_en,
  input  logic [SET_W-1:0]           touch_set,
  input  logic [WAY_W-1:0]           touch_way,
  input  logic                       adv_en,
  input  logic [SET_W-1:0]           adv_set,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0][WAY_W-1:0] rd_age,
  output logic [WAY_W-1:0]           rd_ptr
);

  logic [WAYS-1:0][WAY_W-1:0] age_all [SETS];
  logic [WAY_W-1:0]           ptr_all [SETS];
  logic [WAYS-1:0][WAY_W-1:0] touch_old, touch_new;
  logic [WAY_W-1:0]           ptr_next;

  // Next-state: the touched way becomes youngest, younger-than-it ways age by one
  always_comb begin
    touch_old = age_all[touch_set];
    touch_new = touch_old;
    for (int w = 0; w < WAYS; w++) begin
      if (touch_old[w] < touch_old[touch_way]) touch_new[w] = touch_old[w] + 1'b1;
    end
    touch_new[touch_way] = '0;
    ptr_next = ptr_all[adv_set] + 1'b1;
    rd_age   = age_all[rd_set];
    rd_ptr   = ptr_all[rd_set];
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][WAY_W-1:0] age_r;
    logic [WAY_W-1:0]           ptr_r;
    logic                       age_en, ptr_en;

    assign age_en     = touch_en && (touch_set == SET_W'(s));
    assign ptr_en     = adv_en && (adv_set == SET_W'(s));
    assign age_all[s] = age_r;
    assign ptr_all[s] = ptr_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) age_r[w] <= WAY_W'(w);
        ptr_r <= '0;
      end else begin
        if (age_en) age_r <= touch_new;
        if (ptr_en) ptr_r <= ptr_next;
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int WAYS     = 8,
  parameter int SETS     = 64,
  parameter int MID_X    = 4,
  parameter int BIG_X    = 8,
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SET_W   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lru_mode,
  input  logic             lkp_req,
  input  logic [VA_W-1:0]  lkp_va,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             fill_req,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_size,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn
);

  // Entry storage
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             valid_d [SETS];
  logic [WAYS-1:0][1:0]        size_q  [SETS];
  logic [WAYS-1:0][VPN_W-1:0]  vpn_q   [SETS];
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q   [SETS];
  logic [SETS*WAYS-1:0]        valid_flat;

  // Lookup path
  logic [VPN_W-1:0] lkp_vpn;
  logic [SET_W-1:0] lkp_set;
  logic [WAYS-1:0]  lkp_hit;
  logic             one_hit, many_hit;
  logic [WAY_W-1:0] lkp_way;
  logic [PPN_W-1:0] sel_ppn, pmask, pa_pn;
  logic [1:0]       sel_size;

  // Invalidate and fill paths
  logic [SET_W-1:0]           inv_set, fill_set;
  logic [WAYS-1:0]            inv_hit;
  logic                       fill_acc, set_full;
  logic [WAY_W-1:0]           victim;
  logic [WAYS-1:0][WAY_W-1:0] fill_age;
  logic [WAY_W-1:0]           fill_ptr;

  // Replacement control
  logic             touch_en, adv_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  assign lkp_vpn  = lkp_va[VA_W-1:PG_SHIFT];
  assign lkp_set  = lkp_vpn[SET_W-1:0];
  assign inv_set  = inv_vpn[SET_W-1:0];
  assign fill_set = fill_vpn[SET_W-1:0];
  assign fill_acc = fill_req && !inv_all && !inv_one && (pg_size_e'(fill_size) != PG_RSVD);

  tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_X(MID_X), .BIG_X(BIG_X)) u_lkp_match (
    .way_valid (valid_q[lkp_set]),
    .way_size  (size_q[lkp_set]),
    .way_vpn   (vpn_q[lkp_set]),
    .probe_vpn (lkp_vpn),
    .way_hit   (lkp_hit)
  );

  tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .MID_X(MID_X), .BIG_X(BIG_X)) u_inv_match (
    .way_valid (valid_q[inv_set]),
    .way_size  (size_q[inv_set]),
    .way_vpn   (vpn_q[inv_set]),
    .probe_vpn (inv_vpn),
    .way_hit   (inv_hit)
  );

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .way_valid (valid_q[fill_set]),
    .way_age   (fill_age),
    .rr_ptr    (fill_ptr),
    .lru_mode  (lru_mode),
    .victim    (victim),
    .set_full  (set_full)
  );

  tlb_repl #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .adv_en    (adv_en),
    .adv_set   (fill_set),
    .rd_set    (fill_set),
    .rd_age    (fill_age),
    .rd_ptr    (fill_ptr)
  );

  // Hit classification and physical address composition
  always_comb begin
    one_hit  = $onehot(lkp_hit);
    many_hit = (|lkp_hit) && !one_hit;
    lkp_way  = '0;
    sel_ppn  = '0;
    sel_size = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkp_hit[w]) begin
        lkp_way  = WAY_W'(w);
        sel_ppn  = sel_ppn | ppn_q[lkp_set][w];
        sel_size = sel_size | size_q[lkp_set][w];
      end
    end
    pmask = {PPN_W{1'b1}} << size_low_bits(sel_size, MID_X, BIG_X);
    pa_pn = (sel_ppn & pmask) | (PPN_W'(lkp_vpn) & ~pmask);
  end

  // Replacement touches: an accepted fill wins over a lookup hit
  always_comb begin
    touch_en  = fill_acc || (lkp_req && one_hit);
    touch_set = fill_acc ? fill_set : lkp_set;
    touch_way = fill_acc ? victim : lkp_way;
    adv_en    = fill_acc && set_full && !lru_mode;
  end

  // Valid next state
  always_comb begin
    for (int s = 0; s < SETS; s++) valid_d[s] = valid_q[s];
    if (inv_all) begin
      for (int s = 0; s < SETS; s++) valid_d[s] = '0;
    end else begin
      if (inv_one) valid_d[inv_set] = valid_q[inv_set] & ~inv_hit;
      if (fill_acc) valid_d[fill_set][victim] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  // Entry payload: written on accepted fill only
  always_ff @(posedge clk) begin
    if (fill_acc) begin
      size_q[fill_set][victim] <= fill_size;
      vpn_q[fill_set][victim]  <= fill_vpn;
      ppn_q[fill_set][victim]  <= fill_ppn;
    end
  end

  // Lookup response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lkp_req;
      rsp_hit   <= lkp_req && one_hit;
      rsp_multi <= lkp_req && many_hit;
      if (lkp_req && one_hit) rsp_pa <= {pa_pn, lkp_va[PG_SHIFT-1:0]};
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) valid_flat[s*WAYS +: WAYS] = valid_q[s];
  end

endmodule

// File: rtl/tlb_xlate_cache_chk.sv
module tlb_xlate_cache_chk #(
  parameter int NENT = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lkp_req,
  input logic            fill_req,
  input logic            inv_all,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_multi,
  input logic [NENT-1:0] valid_flat
);

  // R1
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lkp_req));

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> rsp_valid);

  // R4
  hit_multi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_multi));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_flat == '0));

  // R5
  one_fill_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_flat) <= $past($countones(valid_flat)) + 1);

  // R10
  no_fill_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_req |=> $countones(valid_flat) <= $past($countones(valid_flat)));

endmodule

bind tlb_xlate_cache tlb_xlate_cache_chk #(.NENT(SETS * WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lkp_req    (lkp_req),
  .fill_req   (fill_req),
  .inv_all    (inv_all),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_multi  (rsp_multi),
  .valid_flat (valid_flat)
);

// File: tb/tlb_xlate_cache_test.sv
module tlb_xlate_cache_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lru_mode = 1'b1;
  logic        lkp_req = 1'b0;
  logic [31:0] lkp_va = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [31:0] rsp_pa;
  logic        fill_req = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_size = '0;
  logic        inv_all = 1'b0, inv_one = 1'b0;
  logic [19:0] inv_vpn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode),
    .lkp_req(lkp_req), .lkp_va(lkp_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn)
  );

  // Reference model of the cache contents and replacement state
  bit        mv   [64][8];
  bit [1:0]  msz  [64][8];
  bit [19:0] mvpn [64][8];
  bit [19:0] mppn [64][8];
  int        mage [64][8];
  int        mrr  [64];

  function automatic bit [19:0] szmask(bit [1:0] s);
    case (s)
      2'd1:    return 20'hFFFF0;
      2'd2:    return 20'hFFF00;
      default: return 20'hFFFFF;
    endcase
  endfunction

  function automatic bit covers(int s, int w, bit [19:0] vpn);
    return mv[s][w] && (((mvpn[s][w] ^ vpn) & szmask(msz[s][w])) == 20'h0);
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < 64; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < 8; w++) begin mv[s][w] = 0; mage[s][w] = w; end
    end
  endfunction

  function automatic void touch(int s, int w);
    int a = mage[s][w];
    for (int v = 0; v < 8; v++) if (mage[s][v] < a) mage[s][v]++;
    mage[s][w] = 0;
  endfunction

  function automatic int pick_victim(int s, bit lru);
    for (int w = 0; w < 8; w++) if (!mv[s][w]) return w;
    if (lru) begin
      for (int w = 0; w < 8; w++) if (mage[s][w] == 7) return w;
    end
    return mrr[s];
  endfunction

  function automatic bit set_full(int s);
    for (int w = 0; w < 8; w++) if (!mv[s][w]) return 0;
    return 1;
  endfunction

  task automatic check(bit ok, string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {valid,hit,multi,pa}=%h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, update model, check at next negedge
  task automatic step(bit lk, bit [31:0] va, bit fl, bit [19:0] fv, bit [19:0] fp,
                      bit [1:0] fs, bit ia, bit io, bit [19:0] iv, string tag);
    int s, nh, hw, fsi, vw;
    bit ehit, emul, facc, full;
    bit [31:0] epa;
    bit [19:0] m;
    string req;
    lkp_req = lk; lkp_va = va; fill_req = fl; fill_vpn = fv; fill_ppn = fp;
    fill_size = fs; inv_all = ia; inv_one = io; inv_vpn = iv;
    s = int'(va[17:12]); nh = 0; hw = 0; epa = '0;
    for (int w = 0; w < 8; w++) if (covers(s, w, va[31:12])) begin nh++; hw = w; end
    ehit = (nh == 1); emul = (nh > 1);
    if (ehit) begin
      m = szmask(msz[s][hw]);
      epa = {(mppn[s][hw] & m) | (va[31:12] & ~m), va[11:0]};
    end
    facc = fl && !ia && !io && (fs != 2'd3);
    if (ia) begin
      for (int a = 0; a < 64; a++) for (int w = 0; w < 8; w++) mv[a][w] = 0;
    end else if (io) begin
      for (int w = 0; w < 8; w++) if (covers(int'(iv[5:0]), w, iv)) mv[iv[5:0]][w] = 0;
    end
    if (facc) begin
      fsi = int'(fv[5:0]);
      full = set_full(fsi);
      vw = pick_victim(fsi, lru_mode);
      mv[fsi][vw] = 1; msz[fsi][vw] = fs; mvpn[fsi][vw] = fv; mppn[fsi][vw] = fp;
      if (full && !lru_mode) mrr[fsi] = (mrr[fsi] + 1) % 8;
      touch(fsi, vw);
    end else if (lk && ehit) begin
      touch(s, hw);
    end
    @(posedge clk);
    @(negedge clk);
    if (tag != "") req = tag;
    else if (!lk) req = "R1";
    else req = emul ? "R4" : (ehit ? "R2" : "R3");
    begin
      logic [34:0] act, exp;
      act = {rsp_valid, rsp_hit, rsp_multi, (lk && ehit) ? rsp_pa : 32'h0};
      exp = {lk, lk && ehit, lk && emul, (lk && ehit) ? epa : 32'h0};
      check(act === exp, req, act, exp);
    end
    lkp_req = 0; fill_req = 0; inv_all = 0; inv_one = 0;
  endtask

  task automatic look(bit [31:0] va, string tag);
    step(1, va, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(bit [19:0] fv, bit [19:0] fp, bit [1:0] fs);
    step(0, 0, 1, fv, fp, fs, 0, 0, 0, "R5");
  endtask

  task automatic inval(bit ia, bit io, bit [19:0] iv, string tag);
    step(0, 0, 0, 0, 0, 0, ia, io, iv, tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1", {rsp_valid, rsp_hit, 33'h0}, 35'h0);
    look(32'h0000_3000, "R1");

    // R2: translation per size
    fill(20'h00003, 20'h12345, 2'd0);
    look(32'h0000_3ABC, "R2");            // 0x12345ABC
    fill(20'h00A05, 20'h80000, 2'd2);
    look(32'h00A0_5123, "R2");            // 0x80005123
    fill(20'h01012, 20'h45670, 2'd1);
    look(32'h0101_2FFF, "R2");            // 0x45672FFF

    // R3: tag over bits above size; other sets miss
    look(32'h0101_3000, "R3");            // other set: miss
    look(32'h0111_2000, "R3");            // same set, differs above 64K: miss
    look(32'h00A4_5000, "R3");            // differs below 1M: hit 0x80045000
    look(32'h00A0_6000, "R3");            // 1M page not in set 6: miss

    // R9: per-address invalidate touches only its set
    fill(20'h02040, 20'h33330, 2'd1);
    fill(20'h02041, 20'h33330, 2'd1);
    inval(0, 1, 20'h02041, "R9");
    look(32'h0204_1000, "R9");            // miss
    look(32'h0204_0000, "R9");            // hit 0x33330000
    inval(0, 1, 20'h02040, "R9");
    look(32'h0204_0000, "R9");            // miss
    inval(0, 1, 20'h00A85, "R9");         // same set 5, inside 1M page
    look(32'h00A0_5000, "R9");            // miss

    // R4: overlapping entries
    fill(20'h03007, 20'h90000, 2'd2);
    fill(20'h03007, 20'h11111, 2'd0);
    look(32'h0300_7004, "R4");            // multi
    look(32'h0304_7000, "R4");            // only 1M covers: 0x90047000

    // R8: flush
    inval(1, 0, 0, "R8");
    look(32'h0300_7000, "R8");
    look(32'h0000_3000, "R8");

    // R5: reserved size dropped
    fill(20'h00004, 20'h55555, 2'd3);
    look(32'h0000_4000, "R5");

    // R6: least-recently-used victim
    lru_mode = 1;
    for (int k = 0; k < 8; k++) fill(20'((k << 6) | 9), 20'(k + 'h100), 2'd0);
    look(32'h0000_9000, "R6");            // touch k=0
    fill(20'((8 << 6) | 9), 20'h00108, 2'd0);
    look({12'h0, 2'b0, 6'd1, 6'd9, 12'h0}, "R6");  // k=1 evicted: miss
    look(32'h0000_9000, "R6");            // k=0 hit
    look({12'h0, 2'b0, 6'd8, 6'd9, 12'h0}, "R6");  // new page hit

    // R7: round-robin victim
    inval(1, 0, 0, "R8");
    lru_mode = 0;
    for (int k = 0; k < 8; k++) fill(20'((k << 6) | 10), 20'(k + 'h200), 2'd0);
    look(32'h0000_A000, "R7");            // hit, no effect on pointer
    fill(20'((8 << 6) | 10), 20'h00208, 2'd0);
    look(32'h0000_A000, "R7");            // way 0 replaced: miss
    fill(20'((9 << 6) | 10), 20'h00209, 2'd0);
    look({12'h0, 2'b0, 6'd1, 6'd10, 12'h0}, "R7"); // way 1 replaced: miss
    look({12'h0, 2'b0, 6'd2, 6'd10, 12'h0}, "R7"); // hit

    // R10: coinciding operations
    inval(1, 0, 0, "R8");
    step(1, 32'h0005_0000, 1, 20'h00050, 20'h77777, 2'd0, 0, 0, 0, "R10"); // miss
    look(32'h0005_0010, "R10");                                             // hit
    step(1, 32'h0005_0020, 0, 0, 0, 2'd0, 1, 0, 0, "R10");                  // hit
    look(32'h0005_0000, "R10");                                             // miss
    step(0, 0, 1, 20'h00060, 20'h66666, 2'd0, 0, 1, 20'h00999, "R10");
    look(32'h0006_0000, "R10");                                             // miss
    step(0, 0, 1, 20'h00061, 20'h66666, 2'd2, 1, 1, 20'h00061, "R10");
    look(32'h0006_1000, "R10");                                             // miss

    // Random phases: LRU then round-robin
    for (int ph = 0; ph < 2; ph++) begin
      lru_mode = (ph == 0);
      inval(1, 0, 0, "R8");
      for (int n = 0; n < 2500; n++) begin
        bit [19:0] lv, fv, iv;
        bit lk, fl, ia, io;
        bit [1:0] fs;
        int r;
        lv = 20'(($urandom_range(0, 3) << 8) | ($urandom_range(0, 3) << 4) | $urandom_range(0, 3));
        fv = 20'(($urandom_range(0, 3) << 8) | ($urandom_range(0, 3) << 4) | $urandom_range(0, 3));
        iv = 20'(($urandom_range(0, 3) << 8) | ($urandom_range(0, 3) << 4) | $urandom_range(0, 3));
        lk = ($urandom_range(0, 9) < 7);
        fl = ($urandom_range(0, 9) < 4);
        io = ($urandom_range(0, 99) < 4);
        ia = ($urandom_range(0, 99) < 1);
        r  = $urandom_range(0, 9);
        fs = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
        step(lk, {lv, 12'($urandom)}, fl, fv, 20'($urandom), fs, ia, io, iv, "");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule